// File: doc/BRIEF.md
# Memory Access Attribute Resolver

This block decides the effective access attributes of every memory reference that comes from the processor core or from the debug port. The upper address bits are compared against two programmable regions. Each region has a base, a per-bit ignore mask and an enable. The region with the lower index wins. If neither region matches, the default attributes from the control word apply. The result has three flags: cacheable, imprecise operand-write handling and write-protect. A separate flag reports that the address lies in the tightly coupled SRAM window. When that flag is set, the cache discards its data and no external reference is made.

The settings are loaded through a simple write port. A small two-state machine presents one result for each accepted request. States: `ST_IDLE` (no result shown) and `ST_RESULT` (a result is valid). Transitions: `T_WAIT` (ST_IDLE to ST_IDLE, no request), `T_ACCEPT` (ST_IDLE to ST_RESULT, request seen), `T_STREAM` (ST_RESULT to ST_RESULT, another request) and `T_DRAIN` (ST_RESULT to ST_IDLE, no request).

Top module: `mar_resolver`

## Requirements
- R1: After reset, `res_valid` is 0, both regions are disabled, the SRAM window is disabled and the default attributes are 000. A request after reset therefore yields cacheable=0, imprecise=0, wprot=0 and sram=0.
- R2: A region setting word is 20 bits wide: [19:12] base, matched against address bits [31:24]; [11:4] mask, where a 1 ignores that address bit; [3] enable; [2] wprot; [1] imprecise; [0] cacheable. It is written with `cfg_sel` equal to the region index (0 or 1). An enabled region whose unmasked bits equal the base supplies its attribute bits.
- R3: When both regions match, region 0's attributes are used.
- R4: When region 0 does not match and region 1 does, region 1's attributes are used.
- R5: When neither region matches, the default attributes apply. They are written with `cfg_sel`=2 and taken from `cfg_wdata[2:0]` in the same bit order as in R2.
- R6: A region whose enable bit is 0 never matches, whatever its base and mask hold.
- R7: A request sampled with `req_valid` high produces `res_valid` high exactly one clock later, with `res_src` equal to the `req_src` of that request. Back-to-back requests give back-to-back results. When `res_valid` is low, all attribute outputs and `res_sram` are 0.
- R8: The SRAM window is written with `cfg_sel`=3: [19:4] base, matched against address bits [31:16]; [3] enable. `res_sram` is 1 only when the window is enabled and those address bits equal the base. The attribute outputs are resolved independently of `res_sram`.
- R9: A setting write in the same cycle as a request does not affect that request. It takes effect for requests from the next cycle on. Settings change only on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | 2 | Setting target: 0/1 region, 2 default, 3 SRAM window |
| cfg_wdata | input | 20 | Setting word |
| req_valid | input | 1 | Request strobe |
| req_src | input | 1 | Request source tag: 0 core, 1 debug |
| req_addr | input | 32 | Request address |
| res_valid | output | 1 | Result valid |
| res_src | output | 1 | Source tag of the result |
| res_cacheable | output | 1 | Effective cacheable flag |
| res_imprecise | output | 1 | Effective imprecise-write flag |
| res_wprot | output | 1 | Effective write-protect flag |
| res_sram | output | 1 | Address lies in the SRAM window |

## Verification
A setting write and a request can land on the same clock edge. A request can also come in the very next cycle after the write. The bench provokes both. It issues a request together with a write to the default attributes and expects the old defaults in the result. The following request must then show the new defaults. It also sends two requests back to back with different source tags. Each result must appear exactly one cycle after its own request and carry that request's tag.

// File: rtl/mar_pkg.sv
package mar_pkg;
    localparam int REGION_CMP_W = 8;
    localparam int CFG_W        = 2 * REGION_CMP_W + 4;

    typedef struct packed {
        logic wprot;
        logic imprecise;
        logic cacheable;
    } attr_t;

    typedef struct packed {
        logic [REGION_CMP_W-1:0] base;
        logic [REGION_CMP_W-1:0] mask;
        logic                    en;
        attr_t                   attr;
    } region_t;

    typedef enum logic {
        ST_IDLE,
        ST_RESULT
    } res_state_t;
endpackage

// File: rtl/mar_cfg_regs.sv
module mar_cfg_regs
    import mar_pkg::*;
#(
    parameter int NUM_REGIONS = 2,
    parameter int SRAM_CMP_W  = 16,
    parameter int SEL_W       = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [SEL_W-1:0]              cfg_sel,
    input  logic [CFG_W-1:0]              cfg_wdata,
    output region_t [NUM_REGIONS-1:0]     regions_o,
    output attr_t                         dflt_o,
    output logic [SRAM_CMP_W-1:0]         sram_base_o,
    output logic                          sram_en_o
);
    localparam int DFLT_SEL = NUM_REGIONS;
    localparam int SRAM_SEL = NUM_REGIONS + 1;

    for (genvar gi = 0; gi < NUM_REGIONS; gi++) begin : g_region
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regions_o[gi] <= '0;
            end else if (cfg_we && (int'(cfg_sel) == gi)) begin
                regions_o[gi] <= region_t'(cfg_wdata);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dflt_o      <= '0;
            sram_base_o <= '0;
            sram_en_o   <= 1'b0;
        end else if (cfg_we) begin
            if (int'(cfg_sel) == DFLT_SEL) begin
                dflt_o <= attr_t'(cfg_wdata[2:0]);
            end
            if (int'(cfg_sel) == SRAM_SEL) begin
                sram_base_o <= cfg_wdata[CFG_W-1 -: SRAM_CMP_W];
                sram_en_o   <= cfg_wdata[3];
            end
        end
    end
endmodule

// File: rtl/mar_region_match.sv
module mar_region_match
    import mar_pkg::*;
(
    input  region_t                 region_i,
    input  logic [REGION_CMP_W-1:0] addr_hi_i,
    output logic                    hit_o
);
    logic [REGION_CMP_W-1:0] diff;

    always_comb begin
        diff  = (addr_hi_i ^ region_i.base) & ~region_i.mask;
        hit_o = region_i.en && (diff == '0);
    end
endmodule

// File: rtl/mar_resolver.sv
module mar_resolver
    import mar_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int NUM_REGIONS = 2,
    parameter int SRAM_CMP_W  = 16,
    parameter int SEL_W       = $clog2(NUM_REGIONS + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 req_valid,
    input  logic                 req_src,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 res_valid,
    output logic                 res_src,
    output logic                 res_cacheable,
    output logic                 res_imprecise,
    output logic                 res_wprot,
    output logic                 res_sram
);
    localparam int FLAT_W = NUM_REGIONS * $bits(region_t) + $bits(attr_t) + SRAM_CMP_W + 1;

    region_t [NUM_REGIONS-1:0] regions;
    attr_t                     dflt;
    logic [SRAM_CMP_W-1:0]     sram_base;
    logic                      sram_en;
    logic [NUM_REGIONS-1:0]    hit;
    logic [FLAT_W-1:0]         cfg_flat;
    logic                      unused_addr_low;

    attr_t      attr_d, attr_q;
    logic       sram_d, sram_q, src_q;
    res_state_t st_q, st_d;

    mar_cfg_regs #(
        .NUM_REGIONS (NUM_REGIONS),
        .SRAM_CMP_W  (SRAM_CMP_W),
        .SEL_W       (SEL_W)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .regions_o   (regions),
        .dflt_o      (dflt),
        .sram_base_o (sram_base),
        .sram_en_o   (sram_en)
    );

    for (genvar gi = 0; gi < NUM_REGIONS; gi++) begin : g_match
        mar_region_match u_match (
            .region_i  (regions[gi]),
            .addr_hi_i (req_addr[ADDR_W-1 -: REGION_CMP_W]),
            .hit_o     (hit[gi])
        );
    end

    assign cfg_flat        = {regions, dflt, sram_base, sram_en};
    assign unused_addr_low = ^req_addr[ADDR_W-SRAM_CMP_W-1:0];

    // Fixed priority: the lowest matching region index wins, else defaults.
    always_comb begin
        attr_d = dflt;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (hit[i]) begin
                attr_d = regions[i].attr;
            end
        end
        sram_d = sram_en && (req_addr[ADDR_W-1 -: SRAM_CMP_W] == sram_base);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions: T_WAIT, T_ACCEPT, T_STREAM, T_DRAIN
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   st_d = req_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: st_d = req_valid ? ST_RESULT : ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // Result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr_q <= '0;
            sram_q <= 1'b0;
            src_q  <= 1'b0;
        end else if (req_valid) begin
            attr_q <= attr_d;
            sram_q <= sram_d;
            src_q  <= req_src;
        end
    end

    // Outputs
    always_comb begin
        res_valid     = (st_q == ST_RESULT);
        res_src       = res_valid & src_q;
        res_cacheable = res_valid & attr_q.cacheable;
        res_imprecise = res_valid & attr_q.imprecise;
        res_wprot     = res_valid & attr_q.wprot;
        res_sram      = res_valid & sram_q;
    end
endmodule

// File: rtl/mar_chk.sv
module mar_chk #(
    parameter int FLAT_W = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              req_valid,
    input logic              req_src,
    input logic              res_valid,
    input logic              res_src,
    input logic              res_cacheable,
    input logic              res_imprecise,
    input logic              res_wprot,
    input logic              res_sram,
    input logic [FLAT_W-1:0] cfg_flat
);
    p_resp_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    p_resp_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);

    p_src_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (res_src == $past(req_src)));

    p_quiet_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(res_cacheable | res_imprecise | res_wprot | res_sram));

    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_flat));
endmodule

bind mar_resolver mar_chk #(
    .FLAT_W (FLAT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .req_valid     (req_valid),
    .req_src       (req_src),
    .res_valid     (res_valid),
    .res_src       (res_src),
    .res_cacheable (res_cacheable),
    .res_imprecise (res_imprecise),
    .res_wprot     (res_wprot),
    .res_sram      (res_sram),
    .cfg_flat      (cfg_flat)
);

// File: tb/mar_resolver_tb.sv
module mar_resolver_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [19:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_src = 1'b0;
    logic [31:0] req_addr = '0;
    logic        res_valid, res_src, res_cacheable, res_imprecise, res_wprot, res_sram;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    mar_resolver u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_sel       (cfg_sel),
        .cfg_wdata     (cfg_wdata),
        .req_valid     (req_valid),
        .req_src       (req_src),
        .req_addr      (req_addr),
        .res_valid     (res_valid),
        .res_src       (res_src),
        .res_cacheable (res_cacheable),
        .res_imprecise (res_imprecise),
        .res_wprot     (res_wprot),
        .res_sram      (res_sram)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] region_word(logic [7:0] base, logic [7:0] mask,
                                                logic en, logic [2:0] attr);
        return {base, mask, en, attr};
    endfunction

    task automatic write_cfg(logic [1:0] sel, logic [19:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issue one request; result is {valid, src, sram, wprot, imprecise, cacheable}
    task automatic request(logic [31:0] addr, logic src, output logic [5:0] res);
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_src = src;
        @(negedge clk);
        req_valid = 1'b0;
        res = {res_valid, res_src, res_sram, res_wprot, res_imprecise, res_cacheable};
    endtask

    task automatic t_reset();
        logic [5:0] r;
        check("R1 idle valid", res_valid, 0);
        request(32'h4A00_1000, 1'b0, r);
        check("R1 reset attrs", r, 6'b100000);
    endtask

    task automatic t_region0();
        logic [5:0] r;
        write_cfg(2'd0, region_word(8'h40, 8'h0F, 1'b1, 3'b101));
        request(32'h4A00_1000, 1'b0, r);
        check("R2 masked match", r, 6'b100101);
        request(32'h5000_0000, 1'b0, r);
        check("R5 miss defaults", r, 6'b100000);
    endtask

    task automatic t_priority();
        logic [5:0] r;
        write_cfg(2'd1, region_word(8'h00, 8'hFF, 1'b1, 3'b010));
        request(32'h4300_0000, 1'b0, r);
        check("R3 region0 wins", r, 6'b100101);
        request(32'h9000_0000, 1'b0, r);
        check("R4 region1 used", r, 6'b100010);
    endtask

    task automatic t_disable();
        logic [5:0] r;
        write_cfg(2'd2, 20'h00006);
        write_cfg(2'd1, region_word(8'h00, 8'hFF, 1'b0, 3'b010));
        request(32'h9000_0000, 1'b0, r);
        check("R6 region1 off / R5 default", r, 6'b100110);
        write_cfg(2'd0, region_word(8'h40, 8'h0F, 1'b0, 3'b101));
        request(32'h4A00_0000, 1'b0, r);
        check("R6 region0 off", r, 6'b100110);
    endtask

    task automatic t_sram();
        logic [5:0] r;
        write_cfg(2'd3, {16'h2000, 1'b1, 3'b000});
        request(32'h2000_ABCD, 1'b0, r);
        check("R8 window hit", r, 6'b101110);
        request(32'h2001_0000, 1'b0, r);
        check("R8 window miss", r, 6'b100110);
        write_cfg(2'd3, {16'h2000, 1'b0, 3'b000});
        request(32'h2000_ABCD, 1'b0, r);
        check("R8 window off", r, 6'b100110);
    endtask

    task automatic t_stream();
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h1000_0000; req_src = 1'b1;
        @(negedge clk);
        check("R7 first result valid", res_valid, 1);
        check("R7 first src", res_src, 1);
        req_addr = 32'h1100_0000; req_src = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 second result valid", res_valid, 1);
        check("R7 second src", res_src, 0);
        @(negedge clk);
        check("R7 drain", {res_valid, res_wprot, res_imprecise}, 0);
    endtask

    task automatic t_same_cycle();
        logic [5:0] r;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h9000_0000; req_src = 1'b0;
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 20'h00001;
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        check("R9 old defaults", {res_valid, res_wprot, res_imprecise, res_cacheable}, 4'b1110);
        request(32'h9000_0000, 1'b0, r);
        check("R9 new defaults", r, 6'b100001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_region0();
        t_priority();
        t_disable();
        t_sram();
        t_stream();
        t_same_cycle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule